// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block turns the serial frames sent by a PS/2 keyboard into bytes. It watches the keyboard's open-collector clock and data lines. Each line passes through a two-flop synchroniser clocked by the system clock. On every falling edge of the synchronised keyboard clock, the block samples the data line. A frame is one start bit (0), eight data bits sent least significant bit first, one odd-parity bit and one stop bit (1).

A frame that passes every check is delivered on a valid/ready byte stream. A parity error discards the byte and pulses a request to a separate transmitter, which should send the resend command 0xFE to the keyboard. A frame that stalls part way is dropped by an inactivity timer. The timer counts pulses of a 1 µs tick input, and a parameter sets its length; the default is 100 µs. While the transmitter owns the bus, `tx_busy` is high and clock edges are ignored.

The keyboard cannot be paused, so the output stream has no way to push back on it. A byte that completes while the previous one is still unaccepted is dropped. The held byte is kept unchanged.

Top module: `ps2_frame_rx`

## Requirements
- R1: After reset, `out_valid` and `tx_req` are 0 and `tx_byte` reads 0xFE.
- R2: A frame with start bit 0, eight data bits (least significant bit first), a parity bit equal to 1 exactly when the data holds an even number of ones, and stop bit 1 produces `out_valid`=1 with `out_data` equal to the eight data bits.
- R3: A falling clock edge that samples data=1 while the receiver is idle is ignored. The receiver stays idle, so a following well-formed frame is received correctly.
- R4: A parity mismatch discards the byte (no `out_valid`) and raises `tx_req` for exactly one cycle, with `tx_byte` = 0xFE.
- R5: A stop bit of 0 discards the byte, returns the receiver to idle and does not raise `tx_req`.
- R6: If the receiver is in a frame and TIMEOUT_US ticks of `us_tick` arrive with no clock edge between them, the partial frame is abandoned. Gaps of TIMEOUT_US-1 ticks between bits do not abandon a frame.
- R7: While `tx_busy` is 1, falling edges of the keyboard clock are ignored and the receiver state does not move.
- R8: `out_valid` stays 1 and `out_data` stays unchanged until `out_ready` is 1. A byte that completes while `out_valid`=1 and `out_ready`=0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| kb_dat_i | input | 1 | Keyboard data line (asynchronous) |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| tx_busy | input | 1 | Transmitter owns the bus; ignore clock edges |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | `out_data` holds an unaccepted byte |
| out_ready | input | 1 | Consumer accepts the byte this cycle |
| tx_req | output | 1 | One-cycle request to send `tx_byte` |
| tx_byte | output | 8 | Command to transmit on request (0xFE) |

## Verification
The byte path is swept with well-formed frames for all 256 data values. This separates bit-order and parity-sense errors, which break only some values, from errors in the shift marker, which break all of them. Frames with a flipped parity bit, or with a zero stop bit, show whether each error reaches the right outcome: a resend request, or a silent drop.

Stray idle edges with data high, frames clocked while `tx_busy` is high, and partial frames followed by tick gaps of TIMEOUT_US and TIMEOUT_US-1 each show up as misalignment of the next frame. Two frames sent back to back without acceptance test the hold-and-drop rule of the output.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] RESEND_CMD = 8'hFE;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_DATA = 2'd1,
    RX_PAR  = 2'd2,
    RX_STOP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_line,
  input  logic dat_line,
  input  logic block,
  output logic fall,
  output logic bit_val
);
  logic [STAGES-1:0] csync;
  logic [STAGES-1:0] dsync;
  logic              cprev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          csync <= '1;
          dsync <= '1;
        end else begin
          csync <= clk_line;
          dsync <= dat_line;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          csync <= '1;
          dsync <= '1;
        end else begin
          csync <= {csync[STAGES-2:0], clk_line};
          dsync <= {dsync[STAGES-2:0], dat_line};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cprev <= 1'b1;
    else        cprev <= csync[STAGES-1];
  end

  assign fall    = cprev & ~csync[STAGES-1] & ~block;
  assign bit_val = dsync[STAGES-1];

  // R7: a blocked edge never reaches the frame logic
  p_block_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    block |-> !fall);
endmodule

// File: rtl/ps2_idle_timer.sv
module ps2_idle_timer #(
  parameter int TIMEOUT_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic fall,
  input  logic us_tick,
  output logic abort
);
  localparam int CW = $clog2(TIMEOUT_US + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_US - 1);

  logic [CW-1:0] cnt;

  assign abort = active & ~fall & us_tick & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!active || fall)   cnt <= '0;
    else if (abort)             cnt <= '0;
    else if (us_tick)           cnt <= cnt + 1'b1;
  end

  // R6: the tick count never passes the timeout length
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(TIMEOUT_US));
endmodule

// File: rtl/ps2_frame_fsm.sv
module ps2_frame_fsm
  import ps2rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              bit_val,
  input  logic              abort,
  output rx_state_e         state_o,
  output logic              active,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_o,
  output logic              par_err
);
  rx_state_e       state;
  logic [BYTE_W:0] shreg;   // marker enters at the top, data shifts right
  logic            par_exp;

  assign par_exp = ~^shreg[BYTE_W:1];
  assign state_o = state;
  assign active  = (state != RX_IDLE);
  assign byte_o  = shreg[BYTE_W:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      shreg     <= '0;
      byte_done <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      par_err   <= 1'b0;
      if (abort) begin
        state <= RX_IDLE;
      end else if (fall) begin
        unique case (state)
          RX_IDLE: if (!bit_val) begin
            state <= RX_DATA;
            shreg <= {1'b1, {BYTE_W{1'b0}}};
          end
          RX_DATA: begin
            shreg <= {bit_val, shreg[BYTE_W:1]};
            if (shreg[1]) state <= RX_PAR;
          end
          RX_PAR: begin
            if (bit_val == par_exp) state <= RX_STOP;
            else begin
              state   <= RX_IDLE;
              par_err <= 1'b1;
            end
          end
          RX_STOP: begin
            state     <= RX_IDLE;
            byte_done <= bit_val;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R3: a high sample in idle is not a start bit
  p_bad_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && fall && bit_val) |=> state == RX_IDLE);
  // R4: a resend request lasts one cycle
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> !par_err);
  // R5: byte acceptance only leaves the stop state
  p_done_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(state) == RX_STOP);
endmodule

// File: rtl/ps2_byte_port.sv
module ps2_byte_port
  import ps2rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);
  logic room;
  assign room = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && room) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: an unaccepted byte is held unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2rx_pkg::*;
#(
  parameter int TIMEOUT_US  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_clk_i,
  input  logic              kb_dat_i,
  input  logic              us_tick,
  input  logic              tx_busy,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              tx_req,
  output logic [BYTE_W-1:0] tx_byte
);
  logic              fall, bit_val, abort, active, byte_done;
  logic [BYTE_W-1:0] rx_byte;
  rx_state_e         st;

  ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clk_line(kb_clk_i), .dat_line(kb_dat_i),
    .block(tx_busy), .fall(fall), .bit_val(bit_val)
  );

  ps2_idle_timer #(.TIMEOUT_US(TIMEOUT_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(active), .fall(fall),
    .us_tick(us_tick), .abort(abort)
  );

  ps2_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fall(fall), .bit_val(bit_val), .abort(abort),
    .state_o(st), .active(active), .byte_done(byte_done), .byte_o(rx_byte),
    .par_err(tx_req)
  );

  ps2_byte_port u_port (
    .clk(clk), .rst_n(rst_n), .in_valid(byte_done), .in_data(rx_byte),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  assign tx_byte = RESEND_CMD;

  // R7: with the bus owned by the transmitter only a timeout may move state
  p_busy_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !abort) |=> $stable(st));
  // R6: a timeout always lands in idle
  p_timeout_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> st == RX_IDLE);
endmodule

// File: tb/tb_ps2_frame_rx.sv
module tb_ps2_frame_rx;
  localparam int TMO = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kb_clk = 1'b1, kb_dat = 1'b1, us_tick = 1'b0, tx_busy = 1'b0;
  logic       out_ready = 1'b0;
  logic [7:0] out_data, tx_byte;
  logic       out_valid, tx_req;

  int n_chk = 0, n_fail = 0, req_cnt = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ps2_frame_rx #(.TIMEOUT_US(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
    .us_tick(us_tick), .tx_busy(tx_busy), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .tx_req(tx_req),
    .tx_byte(tx_byte)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && tx_req) req_cnt <= req_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1'b1;
      @(negedge clk); us_tick = 1'b0;
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); kb_dat = b;
    wait_n(6);
    kb_clk = 1'b0;
    wait_n(8);
    kb_clk = 1'b1;
    wait_n(6);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip, input logic stop, input int gap);
    logic p;
    p = (~^d) ^ flip;
    send_bit(1'b0);
    ticks(gap);
    for (int i = 0; i < 8; i++) begin
      send_bit(d[i]);
      ticks(gap);
    end
    send_bit(p);
    ticks(gap);
    send_bit(stop);
    kb_dat = 1'b1;
    wait_n(6);
  endtask

  task automatic pop();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  initial begin
    while (!done && cyc < 150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1 reset state
    check("R1 valid", out_valid, 0);
    check("R1 req", tx_req, 0);
    check("R1 cmd", tx_byte, 8'hFE);

    // R2 sweep all byte values
    for (int v = 0; v < 256; v++) begin
      send_frame(v[7:0], 1'b0, 1'b1, 0);
      check("R2 valid", out_valid, 1);
      check("R2 data", out_data, v);
      pop();
    end
    check("R2 no resend", req_cnt, 0);

    // R3 stray idle edge with data high, then a good frame
    send_bit(1'b1);
    send_bit(1'b1);
    check("R3 no byte", out_valid, 0);
    send_frame(8'hA5, 1'b0, 1'b1, 0);
    check("R3 data", out_data, 8'hA5);
    check("R3 valid", out_valid, 1);
    pop();

    // R4 parity errors
    foreach (r_vals[k]) begin
      r = req_cnt;
      send_frame(r_vals[k], 1'b1, 1'b1, 0);
      check("R4 no byte", out_valid, 0);
      check("R4 one pulse", req_cnt - r, 1);
      check("R4 cmd", tx_byte, 8'hFE);
      send_frame(r_vals[k] ^ 8'h0F, 1'b0, 1'b1, 0);
      check("R4 recovers", out_data, r_vals[k] ^ 8'h0F);
      pop();
    end

    // R5 stop bit 0
    r = req_cnt;
    send_frame(8'h3C, 1'b0, 1'b0, 0);
    check("R5 no byte", out_valid, 0);
    check("R5 no req", req_cnt - r, 0);
    send_frame(8'hC3, 1'b0, 1'b1, 0);
    check("R5 next frame", out_data, 8'hC3);
    check("R5 next valid", out_valid, 1);
    pop();

    // R6 timeout abandons a partial frame
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    ticks(TMO);
    send_frame(8'h69, 1'b0, 1'b1, 0);
    check("R6 timeout data", out_data, 8'h69);
    check("R6 timeout valid", out_valid, 1);
    pop();
    // R6 gaps one tick short keep the frame
    send_frame(8'hB2, 1'b0, 1'b1, TMO - 1);
    check("R6 gap data", out_data, 8'hB2);
    check("R6 gap valid", out_valid, 1);
    pop();

    // R7 busy bus ignores edges
    @(negedge clk); tx_busy = 1'b1;
    send_frame(8'h5A, 1'b0, 1'b1, 0);
    check("R7 ignored", out_valid, 0);
    send_bit(1'b0);
    @(negedge clk); tx_busy = 1'b0;
    send_frame(8'h17, 1'b0, 1'b1, 0);
    check("R7 after data", out_data, 8'h17);
    check("R7 after valid", out_valid, 1);
    pop();

    // R8 hold and drop
    send_frame(8'h11, 1'b0, 1'b1, 0);
    send_frame(8'h22, 1'b0, 1'b1, 0);
    check("R8 held data", out_data, 8'h11);
    check("R8 held valid", out_valid, 1);
    pop();
    wait_n(2);
    check("R8 dropped", out_valid, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  logic [7:0] r_vals [4] = '{8'h00, 8'hFF, 8'h81, 8'h7E};
endmodule